// File: doc/BRIEF.md
# Countdown Watchdog with Early-Warning Interrupt

This block is a hardware watchdog timer reached through a small byte-addressed register window. Software loads a tick count and sets a run bit in a control byte. It keeps the system alive by writing a fresh count before the old one runs out. A prescaler turns the core clock into a slow tick. The counter drops by one on every tick while the run bit is set.

Two events come out of the countdown. An optional early-warning stage raises a status bit and an interrupt line once the remaining count falls to a fixed threshold, which is nine seconds' worth of ticks, rounded down. When the count reaches zero the block stops itself, records a timeout in the status byte and, if the reset-enable control bit is set, drives a system reset pulse a few clocks wide. Software can check the status byte to confirm that the watchdog raised the interrupt. It clears that byte by writing ones.

Top module: `wdog_top`

## Requirements
- R1: After reset the control byte reads 0x00, the count reads 0xFFFF, the status byte reads 0x00, and `pre_irq` and `sys_rst_out` are low.
- R2: A write to address 0x70 loads `bus_wdata` into the count, and the new value is readable at 0x70 after that clock edge. While control bit 0 is clear the count does not change.
- R3: While control bit 0 is set, the count drops by exactly one every TICK_CYC = CLK_KHZ*TICK_MS clocks, measured from the edge that set the bit.
- R4: A count write while running reloads the count and restarts the tick phase, so the next decrement comes TICK_CYC clocks after the write.
- R5: The control byte at 0x72 reads back as written. Bit 0 is the run bit. When bit 0 is cleared the count freezes, and the other bits keep their values.
- R6: With control bit 2 set, status bit 1 and `pre_irq` assert one clock after the count is at or below PRE_TICKS = floor(PRE_MS/TICK_MS) while running. With bit 2 clear they never assert.
- R7: The early-warning event fires at most once per count write. After it is cleared it stays clear until the next count write.
- R8: The status byte at 0x6E is write-one-to-clear. Writing a 1 clears that bit, and writing a 0 leaves it unchanged.
- R9: When the count is zero while running, status bit 2 sets and control bit 0 clears one clock later, and the count stays at zero.
- R10: At that expiry, if control bit 7 is set, `sys_rst_out` is high for RST_CYC clocks starting one clock after the count reaches zero. With bit 7 clear it stays low.
- R11: Setting the run bit with a count of zero causes expiry at once, and the reset pulse starts on the next clock.
- R12: Reads of addresses other than 0x6E, 0x70 and 0x72 return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address of the register window |
| bus_wdata | input | 16 | Write data; 8-bit registers use the low byte |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pre_irq | output | 1 | Early-warning interrupt (status bit 1) |
| sys_rst_out | output | 1 | System reset pulse on expiry |

## Verification
Reads are combinational, so the bench samples `bus_rdata` in the low half of the same cycle. A count or control write is visible after the edge that samples it. The first decrement falls TICK_CYC edges after the write that started or reloaded the count. The early-warning status bit lands one edge after the threshold is reached. The reset pulse starts one edge after the count hits zero and lasts RST_CYC edges. The bench drives and samples only on falling edges and works out each expected value from the edge count since the write, as `V - m/TICK_CYC`, using the short tick configuration.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] ADDR_STAT = 8'h6E;
  localparam logic [7:0] ADDR_CNT  = 8'h70;
  localparam logic [7:0] ADDR_CTRL = 8'h72;

  localparam int CTRL_RUN = 0;
  localparam int CTRL_PRE = 2;
  localparam int CTRL_RST = 7;

  localparam int STAT_PRE = 1;
  localparam int STAT_EXP = 2;
  localparam logic [7:0] STAT_MASK = 8'h06;

  function automatic int tick_cycles(input int clk_khz, input int tick_ms);
    return clk_khz * tick_ms;
  endfunction

  function automatic int pre_ticks(input int pre_ms, input int tick_ms);
    return pre_ms / tick_ms;
  endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int TICK_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYC - 1);

  logic [PW-1:0] phase_q;

  assign tick = run && (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phase_q <= '0;
    else if (!run || restart)   phase_q <= '0;
    else if (phase_q == LAST)   phase_q <= '0;
    else                        phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W     = 16,
  parameter int PRE_TICKS = 70
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic             pre_en,
  output logic [CNT_W-1:0] cnt,
  output logic             expire,
  output logic             pre_hit
);
  localparam logic [CNT_W-1:0] PRE_LIM = CNT_W'(PRE_TICKS);

  logic pre_done_q;

  assign expire  = run && (cnt == '0);
  assign pre_hit = run && pre_en && !pre_done_q && (cnt <= PRE_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '1;
    else if (load)                cnt <= load_val;
    else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_done_q <= 1'b0;
    else if (load)     pre_done_q <= 1'b0;
    else if (pre_hit)  pre_done_q <= 1'b1;
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [7:0]       addr,
  input  logic [15:0]      wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             expire,
  input  logic             pre_hit,
  output logic [7:0]       ctrl,
  output logic [7:0]       status,
  output logic [15:0]      rdata,
  output logic             cnt_load,
  output logic             ctrl_wr
);
  logic       stat_wr;
  logic [7:0] stat_set;
  logic [7:0] stat_clr;

  assign cnt_load = wr && (addr == ADDR_CNT);
  assign ctrl_wr  = wr && (addr == ADDR_CTRL);
  assign stat_wr  = wr && (addr == ADDR_STAT);

  always_comb begin
    stat_set = '0;
    stat_set[STAT_PRE] = pre_hit;
    stat_set[STAT_EXP] = expire;
    stat_clr = stat_wr ? wdata[7:0] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= 8'h00;
    else if (ctrl_wr) ctrl <= wdata[7:0];
    else if (expire)  ctrl[CTRL_RUN] <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= 8'h00;
    else        status <= ((status & ~stat_clr) | stat_set) & STAT_MASK;
  end

  always_comb begin
    case (addr)
      ADDR_STAT: rdata = {8'h00, status};
      ADDR_CNT:  rdata = 16'(cnt);
      ADDR_CTRL: rdata = {8'h00, ctrl};
      default:   rdata = 16'h0000;
    endcase
  end
endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
  parameter int RST_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic rst_out
);
  localparam int RW = $clog2(RST_CYC + 1);

  logic [RW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left_q <= '0;
    else if (fire)          left_q <= RW'(RST_CYC);
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign rst_out = (left_q != '0);
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int CLK_KHZ = 100000,
  parameter int TICK_MS = 128,
  parameter int PRE_MS  = 9000,
  parameter int CNT_W   = 16,
  parameter int RST_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        pre_irq,
  output logic        sys_rst_out
);
  localparam int TICK_CYC  = tick_cycles(CLK_KHZ, TICK_MS);
  localparam int PRE_TICKS = pre_ticks(PRE_MS, TICK_MS);

  logic [7:0]       ctrl;
  logic [7:0]       status;
  logic [CNT_W-1:0] cnt;
  logic             cnt_load;
  logic             ctrl_wr;
  logic             tick;
  logic             run;
  logic             rst_en;
  logic             expire;
  logic             pre_hit;

  assign run    = ctrl[CTRL_RUN];
  assign rst_en = ctrl[CTRL_RST];

  wdog_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .cnt(cnt), .expire(expire), .pre_hit(pre_hit), .ctrl(ctrl), .status(status),
    .rdata(bus_rdata), .cnt_load(cnt_load), .ctrl_wr(ctrl_wr)
  );

  wdog_prescaler #(.TICK_CYC(TICK_CYC)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(cnt_load), .tick(tick)
  );

  wdog_counter #(.CNT_W(CNT_W), .PRE_TICKS(PRE_TICKS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load),
    .load_val(bus_wdata[CNT_W-1:0]), .run(run), .pre_en(ctrl[CTRL_PRE]),
    .cnt(cnt), .expire(expire), .pre_hit(pre_hit)
  );

  wdog_rstgen #(.RST_CYC(RST_CYC)) u_rst (
    .clk(clk), .rst_n(rst_n), .fire(expire && rst_en), .rst_out(sys_rst_out)
  );

  assign pre_irq = status[STAT_PRE];
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_load,
  input logic             ctrl_wr,
  input logic [CNT_W-1:0] cnt,
  input logic             run,
  input logic             rst_en,
  input logic             expire,
  input logic             pre_hit,
  input logic             pre_irq,
  input logic             sys_rst
);
  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_load |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));

  // R5
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_load) |=> $stable(cnt));

  // R9
  expire_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl_wr) |=> !run);

  // R10
  rst_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && rst_en) |=> sys_rst);

  // R10
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> $past(expire && rst_en));

  // R6
  pre_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pre_irq) |-> $past(pre_hit));
endmodule

bind wdog_top wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_load(cnt_load), .ctrl_wr(ctrl_wr), .cnt(cnt),
  .run(run), .rst_en(rst_en), .expire(expire), .pre_hit(pre_hit),
  .pre_irq(pre_irq), .sys_rst(sys_rst_out)
);

// File: tb/wdog_top_tb.sv
module wdog_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int KHZ = 1;
  localparam int TMS = 4;
  localparam int PMS = 36;
  localparam int RCY = 3;
  localparam int T   = KHZ * TMS;   // clocks per tick
  localparam int PRE = PMS / TMS;   // early-warning threshold in ticks

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  logic        pre_irq;
  logic        sys_rst_out;

  int n_run = 0;
  int n_fail = 0;

  wdog_top #(.CLK_KHZ(KHZ), .TICK_MS(TMS), .PRE_MS(PMS), .CNT_W(16), .RST_CYC(RCY)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pre_irq(pre_irq),
    .sys_rst_out(sys_rst_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    logic [15:0] v;
    logic [15:0] keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd(8'h6E, v); check("R1 status", v, 16'h0000);
    rd(8'h70, v); check("R1 count", v, 16'hFFFF);
    rd(8'h72, v); check("R1 ctrl", v, 16'h0000);
    check("R1 pre_irq", {15'b0, pre_irq}, 16'h0);
    check("R1 sys_rst", {15'b0, sys_rst_out}, 16'h0);

    // R12 unmapped reads and writes
    wr(8'h40, 16'hFFFF);
    foreach (v[i]) ;
    rd(8'h00, v); check("R12 rd 00", v, 16'h0);
    rd(8'h6F, v); check("R12 rd 6F", v, 16'h0);
    rd(8'h71, v); check("R12 rd 71", v, 16'h0);
    rd(8'h40, v); check("R12 rd 40", v, 16'h0);
    rd(8'h70, v); check("R12 count untouched", v, 16'hFFFF);
    rd(8'h72, v); check("R12 ctrl untouched", v, 16'h0);

    // R2 load while stopped
    wr(8'h70, 16'd100);
    rd(8'h70, v); check("R2 load", v, 16'd100);
    step(20);
    rd(8'h70, v); check("R2 frozen", v, 16'd100);

    // R3 decrement sweep from run edge
    wr(8'h72, 16'h0001);
    rd(8'h72, v); check("R5 run readback", v, 16'h0001);
    for (int m = 1; m <= 40; m++) begin
      step(1);
      rd(8'h70, v); check("R3 sweep", v, 16'(100 - m / T));
    end

    // R4 keep-alive restarts phase
    step(2);
    wr(8'h70, 16'd50);
    for (int m = 1; m <= 12; m++) begin
      step(1);
      rd(8'h70, v); check("R4 reload sweep", v, 16'(50 - m / T));
    end

    // R5 stop preserves other bits, count freezes
    wr(8'h72, 16'h0040);
    rd(8'h72, v); check("R5 ctrl 0x40", v, 16'h0040);
    rd(8'h70, keep); check("R5 count at stop", keep, 16'd47);
    step(20);
    rd(8'h70, v); check("R5 count frozen", v, keep);

    // R6 early warning sweep
    wr(8'h70, 16'd12);
    wr(8'h72, 16'h0005);
    for (int m = 1; m <= 20; m++) begin
      step(1);
      rd(8'h6E, v);
      check("R6 status bit1", v & 16'h0002, (12 - m / T <= PRE && m >= (12 - PRE) * T + 1) ? 16'h0002 : 16'h0000);
      check("R6 pre_irq", {15'b0, pre_irq}, (m >= (12 - PRE) * T + 1) ? 16'h1 : 16'h0);
    end

    // R8 write-zero keeps, write-one clears; R7 stays clear
    wr(8'h6E, 16'h0000);
    rd(8'h6E, v); check("R8 write zero keeps", v, 16'h0002);
    wr(8'h6E, 16'h0002);
    rd(8'h6E, v); check("R8 w1c clears", v, 16'h0000);
    step(8);
    rd(8'h6E, v); check("R7 no refire", v, 16'h0000);
    check("R7 pre_irq low", {15'b0, pre_irq}, 16'h0);
    wr(8'h70, 16'd5);
    rd(8'h6E, v); check("R7 not yet", v, 16'h0000);
    step(1);
    rd(8'h6E, v); check("R7 rearmed by load", v, 16'h0002);
    check("R7 pre_irq", {15'b0, pre_irq}, 16'h1);
    wr(8'h6E, 16'h0002);
    wr(8'h72, 16'h0000);

    // R9 expiry without reset enable, early warning disabled (R6)
    wr(8'h70, 16'd12);
    wr(8'h72, 16'h0001);
    for (int m = 1; m <= 60; m++) begin
      step(1);
      check("R10 no pulse without bit7", {15'b0, sys_rst_out}, 16'h0);
      if (m == 20) begin
        rd(8'h6E, v); check("R6 disabled status", v, 16'h0000);
        check("R6 disabled pre_irq", {15'b0, pre_irq}, 16'h0);
      end
      if (m == 12 * T) begin
        rd(8'h70, v); check("R9 count zero", v, 16'h0000);
        rd(8'h72, v); check("R9 still running", v, 16'h0001);
      end
      if (m == 12 * T + 1) begin
        rd(8'h72, v); check("R9 run cleared", v, 16'h0000);
        rd(8'h6E, v); check("R9 status timeout", v, 16'h0004);
      end
    end
    rd(8'h70, v); check("R9 count holds zero", v, 16'h0000);
    wr(8'h6E, 16'h0004);
    rd(8'h6E, v); check("R8 clear timeout bit", v, 16'h0000);

    // R10 reset pulse
    wr(8'h70, 16'd3);
    wr(8'h72, 16'h0085);
    for (int m = 1; m <= 20; m++) begin
      step(1);
      check("R10 pulse window", {15'b0, sys_rst_out},
            (m >= 3 * T + 1 && m <= 3 * T + RCY) ? 16'h1 : 16'h0);
    end
    rd(8'h72, v); check("R5 only bit0 cleared", v, 16'h0084);
    rd(8'h6E, v); check("R10 timeout recorded", v & 16'h0004, 16'h0004);
    wr(8'h6E, 16'h0006);

    // R11 zero reload expires at once
    wr(8'h70, 16'd0);
    rd(8'h70, v); check("R11 zero loaded", v, 16'h0000);
    wr(8'h72, 16'h0081);
    check("R11 no pulse yet", {15'b0, sys_rst_out}, 16'h0);
    step(1);
    check("R11 pulse", {15'b0, sys_rst_out}, 16'h1);
    rd(8'h72, v); check("R11 stopped", v, 16'h0080);
    rd(8'h6E, v); check("R11 timeout bit", v, 16'h0004);
    step(RCY);
    check("R11 pulse ended", {15'b0, sys_rst_out}, 16'h0);

    finish_up();
  end
endmodule